// File: doc/BRIEF.md
# Lane-Partitioned Packed Integer Adder

This block adds two wide operand vectors as a set of independent integer elements in a single operation. A run-time size code chooses how the vector is split into lanes: 8, 16, 32, 64 or 128 bits per element. The carry chain is cut at every lane edge, so each element wraps on its own and never disturbs its neighbour. A second control picks packed operation, where every lane is summed, or scalar operation, where only the lowest lane is summed and the higher lanes of the second operand pass through unchanged.

An operation is launched by a one-cycle start strobe with both operands, the size code and the scalar control. The result is registered and appears on the next clock with a one-cycle valid pulse. It then holds until the next start. The vector width is a parameter: 128 bits by default, or 64 bits. In the 64-bit build only the 8, 16 and 32-bit element sizes exist. A size code the build does not support returns a zero result with an error flag.

Top module: `simd_lane_adder`

## Requirements
- R1: In packed mode, every lane i of the result equals lane i of operand A plus lane i of operand B, modulo 2 to the lane width. All lanes are computed in the same operation.
- R2: The carry out of a lane's top bit is dropped. Adding all-ones to one in every lane gives zero in every lane, with no carry into the next lane.
- R3: Size code encoding on `elem_size`: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 4 = 128-bit lanes.
- R4: In scalar mode (`scalar_op` = 1), lane 0 of the result holds the lane-0 sum. Every higher lane holds the same lane of operand B.
- R5: `res_valid` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise.
- R6: A size code above 4, or above 2 when DATA_W is 64, gives an all-zero result with `res_err` high, in the same cycle as `res_valid`.
- R7: Lane 0 occupies the least significant bits. Lane i occupies bits i*W to i*W+W-1, where W is the lane width.
- R8: Reset clears `res_data`, `res_valid` and `res_err`. While `start` is low, `res_data` keeps its last value whatever the operands do.
- R9: `res_err` stays low after a start that carries a supported size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, one operation per cycle high |
| elem_size | input | 3 | Lane width code (see R3) |
| scalar_op | input | 1 | 1 = sum lane 0 only, 0 = sum all lanes |
| op_a | input | DATA_W | First operand vector |
| op_b | input | DATA_W | Second operand vector, also the pass-through source |
| res_data | output | DATA_W | Registered result vector |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_err | output | 1 | Unsupported size code seen, qualified by res_valid |

## Verification
A wrong lane-edge mask shows up in the first result after a start whose lanes carry out. The bench therefore pairs all-ones with ones in every size mode, and the leaked carry appears in the next lane on the next cycle. A wrong lane-0 mask shows up in scalar mode as an operand-B byte replaced by a sum, or the reverse. A stuck valid, error or hold register shows up within one cycle, because the reference model is compared with every output on every clock, including idle cycles with changing operands.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    typedef enum logic [2:0] {
        ESZ_8   = 3'd0,
        ESZ_16  = 3'd1,
        ESZ_32  = 3'd2,
        ESZ_64  = 3'd3,
        ESZ_128 = 3'd4
    } elem_size_e;

    typedef struct packed {
        logic       scalar;
        logic [2:0] code;
    } op_ctrl_t;

    localparam int BYTE_W = 8;

    // bytes per lane for a given size code
    function automatic int lane_bytes(input logic [2:0] code);
        return 1 << code;
    endfunction

    // largest size code a vector of the given width supports
    function automatic int max_code(input int vec_w);
        return (vec_w >= 128) ? 4 : 2;
    endfunction

endpackage

// File: rtl/lane_edge_decode.sv
module lane_edge_decode
    import simd_add_pkg::*;
#(
    parameter int NBYTE    = 16,
    parameter int MAX_CODE = 4
) (
    input  op_ctrl_t           ctrl,
    output logic [NBYTE-1:0]   cut,
    output logic [NBYTE-1:0]   low_lane,
    output logic               bad
);
    int lb;

    always_comb begin
        bad = (int'(ctrl.code) > MAX_CODE);
        lb  = lane_bytes(ctrl.code);
        for (int k = 0; k < NBYTE; k++) begin
            cut[k]      = ((k & (lb - 1)) == 0);
            low_lane[k] = (k < lb);
        end
    end
endmodule

// File: rtl/segmented_adder.sv
module segmented_adder
    import simd_add_pkg::*;
#(
    parameter int NBYTE = 16
) (
    input  logic [NBYTE*BYTE_W-1:0] a,
    input  logic [NBYTE*BYTE_W-1:0] b,
    input  logic [NBYTE-1:0]        cut,
    output logic [NBYTE*BYTE_W-1:0] sum
);
    logic [NBYTE-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        logic cin;
        assign cin = cut[g] ? 1'b0 : cy[g];
        if (g < NBYTE - 1) begin : g_mid
            logic [BYTE_W:0] t;
            assign t = {1'b0, a[g*BYTE_W +: BYTE_W]}
                     + {1'b0, b[g*BYTE_W +: BYTE_W]}
                     + {{BYTE_W{1'b0}}, cin};
            assign sum[g*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
            assign cy[g+1] = t[BYTE_W];
        end else begin : g_top
            assign sum[g*BYTE_W +: BYTE_W] = a[g*BYTE_W +: BYTE_W]
                                           + b[g*BYTE_W +: BYTE_W]
                                           + {{(BYTE_W-1){1'b0}}, cin};
        end
    end
endmodule

// File: rtl/result_stage.sv
module result_stage
    import simd_add_pkg::*;
#(
    parameter int NBYTE = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    scalar,
    input  logic                    bad,
    input  logic [NBYTE-1:0]        low_lane,
    input  logic [NBYTE*BYTE_W-1:0] sum,
    input  logic [NBYTE*BYTE_W-1:0] pass,
    output logic [NBYTE*BYTE_W-1:0] q,
    output logic                    valid,
    output logic                    err
);
    logic [NBYTE*BYTE_W-1:0] sel;

    for (genvar g = 0; g < NBYTE; g++) begin : g_sel
        assign sel[g*BYTE_W +: BYTE_W] =
            bad ? '0 :
            ((scalar && !low_lane[g]) ? pass[g*BYTE_W +: BYTE_W]
                                      : sum[g*BYTE_W +: BYTE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            valid <= 1'b0;
            err   <= 1'b0;
        end else begin
            valid <= start;
            err   <= start & bad;
            if (start) q <= sel;
        end
    end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        elem_size,
    input  logic              scalar_op,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              res_err
);
    localparam int NBYTE    = DATA_W / BYTE_W;
    localparam int MAX_CODE = max_code(DATA_W);

    op_ctrl_t          ctrl;
    logic [NBYTE-1:0]  cut;
    logic [NBYTE-1:0]  low_lane;
    logic              bad;
    logic [DATA_W-1:0] sum;

    assign ctrl.scalar = scalar_op;
    assign ctrl.code   = elem_size;

    lane_edge_decode #(.NBYTE(NBYTE), .MAX_CODE(MAX_CODE)) u_dec (
        .ctrl     (ctrl),
        .cut      (cut),
        .low_lane (low_lane),
        .bad      (bad)
    );

    segmented_adder #(.NBYTE(NBYTE)) u_add (
        .a   (op_a),
        .b   (op_b),
        .cut (cut),
        .sum (sum)
    );

    result_stage #(.NBYTE(NBYTE)) u_res (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .scalar   (ctrl.scalar),
        .bad      (bad),
        .low_lane (low_lane),
        .sum      (sum),
        .pass     (op_b),
        .q        (res_data),
        .valid    (res_valid),
        .err      (res_err)
    );
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        elem_size,
    input logic              scalar_op,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic              res_err
);
    logic [7:0] low_byte_sum;
    assign low_byte_sum = op_a[7:0] + op_b[7:0];

    // R5
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> res_valid);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !res_valid);

    // R6
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_err |-> res_valid);

    // R6
    err_zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (res_data == '0));

    // R9
    good_code_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (start && elem_size <= 3'd2) |=> !res_err);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(res_data));

    // R1
    byte_lane0_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (start && elem_size == 3'd0) |=> (res_data[7:0] == $past(low_byte_sum)));

    // R4
    scalar_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (start && scalar_op && elem_size == 3'd0)
        |=> (res_data[DATA_W-1:8] == $past(op_b[DATA_W-1:8])));
endmodule

bind simd_lane_adder simd_lane_adder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .elem_size (elem_size),
    .scalar_op (scalar_op),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_data  (res_data),
    .res_valid (res_valid),
    .res_err   (res_err)
);

// File: tb/simd_lane_adder_test.sv
`timescale 1ns/1ps
module simd_lane_adder_test;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    elem_size = 3'd0;
    logic          scalar_op = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [DW-1:0] res_data;
    logic          res_valid;
    logic          res_err;

    int total = 0;
    int bad   = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R8";

    logic [DW-1:0] exp_data = '0;
    logic          exp_valid = 1'b0;
    logic          exp_err = 1'b0;

    always #5 clk = ~clk;

    simd_lane_adder #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .elem_size(elem_size),
        .scalar_op(scalar_op), .op_a(op_a), .op_b(op_b),
        .res_data(res_data), .res_valid(res_valid), .res_err(res_err)
    );

    // behavioural reference: per-element add built from shifts and masks
    function automatic logic [DW-1:0] ref_sum(input logic [2:0] code, input logic sc,
                                              input logic [DW-1:0] a, input logic [DW-1:0] b,
                                              output logic e);
        logic [DW-1:0] res, mask, la, lb, s;
        int w;
        res = '0;
        if (code > 3'd4) begin
            e = 1'b1;
            return '0;
        end
        e = 1'b0;
        w = 8 << code;
        mask = (w >= DW) ? '1 : ((DW'(1) << w) - DW'(1));
        for (int i = 0; i < DW / w; i++) begin
            la = (a >> (i * w)) & mask;
            lb = (b >> (i * w)) & mask;
            s  = (la + lb) & mask;
            if (sc && i > 0) s = lb;
            res = res | (s << (i * w));
        end
        return res;
    endfunction

    always @(posedge clk) begin
        logic e;
        if (rst) begin
            exp_data  <= '0;
            exp_valid <= 1'b0;
            exp_err   <= 1'b0;
        end else begin
            exp_valid <= start;
            if (start) begin
                exp_data <= ref_sum(elem_size, scalar_op, op_a, op_b, e);
                exp_err  <= e;
            end else begin
                exp_err  <= 1'b0;
            end
        end
        running <= 1'b1;
    end

    always @(negedge clk) begin
        if (running && !finished) begin
            total++;
            if (res_valid !== exp_valid) begin
                bad++;
                $display("FAIL %s valid: got %b want %b", cur_req, res_valid, exp_valid);
            end
            total++;
            if (res_err !== exp_err) begin
                bad++;
                $display("FAIL %s err: got %b want %b", cur_req, res_err, exp_err);
            end
            total++;
            if (res_data !== exp_data) begin
                bad++;
                $display("FAIL %s data: got %h want %h", cur_req, res_data, exp_data);
            end
        end
    end

    task automatic op(input logic [2:0] code, input logic sc,
                      input logic [DW-1:0] a, input logic [DW-1:0] b, input string req);
        cur_req   = req;
        start     = 1'b1;
        elem_size = code;
        scalar_op = sc;
        op_a      = a;
        op_b      = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        cur_req = req;
        start   = 1'b0;
        for (int i = 0; i < n; i++) begin
            op_a = {$urandom, $urandom, $urandom, $urandom};
            op_b = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] ones = '1;
        logic [DW-1:0] a, b;
        repeat (3) @(negedge clk);
        // R8: reset state, checked by the per-cycle compare while rst is high
        cur_req = "R8";
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R8");

        // R1, R3, R7: packed sums in every size, distinct patterns
        for (int c = 0; c <= 4; c++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            op(3'(c), 1'b0, a, b, "R1");
        end
        op(3'd0, 1'b0, 128'h0f0e0d0c0b0a09080706050403020100,
                       128'h01010101010101010101010101010101, "R7");
        op(3'd1, 1'b0, 128'h8000_7fff_0001_ffff_1234_4321_aaaa_5555,
                       128'h8000_0001_ffff_0001_1111_2222_5555_aaab, "R3");
        idle(1, "R5");

        // R2: all-ones plus one per lane must give zero everywhere
        for (int c = 0; c <= 4; c++) begin
            logic [DW-1:0] one_per_lane = '0;
            for (int i = 0; i < DW / (8 << c); i++)
                one_per_lane = one_per_lane | (DW'(1) << (i * (8 << c)));
            op(3'(c), 1'b0, ones, one_per_lane, "R2");
        end

        // R4: scalar mode in every size
        for (int c = 0; c <= 4; c++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            op(3'(c), 1'b1, a, b, "R4");
        end
        op(3'd2, 1'b1, ones, ones, "R4");

        // R6: unsupported codes, then back to a good code (R9)
        op(3'd5, 1'b0, ones, ones, "R6");
        op(3'd6, 1'b1, ones, ones, "R6");
        op(3'd7, 1'b0, ones, ones, "R6");
        op(3'd3, 1'b0, ones, ones, "R9");

        // R8: result holds across idle cycles with changing operands
        idle(5, "R8");

        // R5: isolated and back-to-back starts
        op(3'd0, 1'b0, 128'h5, 128'h7, "R5");
        idle(2, "R5");
        for (int i = 0; i < 20; i++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            op(3'($urandom_range(0, 7)), 1'($urandom), a, b, "R5");
            if (i % 3 == 0) idle(1, "R5");
        end
        idle(3, "R8");

        // R8: reset in the middle clears the outputs
        op(3'd0, 1'b0, ones, ones, "R8");
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R8");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule